// File: doc/BRIEF.md
# Burst SRAM Synchronous Control Front End

This block is the clocked control front end of a flow-through burst SRAM. It holds `2**ADDR_W` words of 18 bits, stored as two 9-bit byte lanes. Each clock edge classifies the cycle from two address strobes, three chip enables, an advance input and the write inputs. Two strobes can start an access. A processor strobe start is always a read. A controller strobe start may write in its own cycle. When neither strobe is low, the cycle carries on an existing burst.

A 2-bit burst counter runs inside the block. It takes the low two address bits at a start and then steps, either linearly or in interleaved order, each time advance is low. Read data comes straight from the array at the registered address, so it appears in the same clock period as the edge that loaded or moved that address. The bidirectional data pads are split into a data-in port, a data-out port and a drive-enable output. The output enable input gates the drive enable with no register in between.

Top module: `ssram_front`

## Requirements
- R1: A new address is loaded only when `en1_n`=0, `en2`=1, `en3_n`=0 and an acted-upon strobe is low. If a strobe is acted upon while these enables are not all active, the cycle deselects the device. `dq_oe` is then 0, and the cycles that continue a burst neither write nor drive until the next valid start.
- R2: When `proc_strobe_n` and `ctrl_strobe_n` are both low and `en1_n`=0, the block acts on the processor strobe alone: the cycle is a read start.
- R3: `proc_strobe_n` is ignored while `en1_n`=1. With `ctrl_strobe_n`=1 that cycle continues the burst already in progress and loads no address.
- R4: A processor strobe start is always a read. `gwr_n`, `bwr_en_n` and `lane_sel_n` have no effect on the array in that cycle.
- R5: A controller strobe start, with the processor strobe not acted upon, writes `dq_in` at `addr` in that same cycle if the write inputs request a write. Otherwise it starts a read.
- R6: In a cycle with no start, `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one. The cycle writes at that address if the write inputs request it, and reads it otherwise.
- R7: `gwr_n`=0 writes both lanes. Otherwise `bwr_en_n`=0 writes lane A (bits 8:0) when `lane_sel_n[0]`=0 and lane B (bits 17:9) when `lane_sel_n[1]`=0. Otherwise the cycle is a read.
- R8: With `burst_mode`=0, the low two address bits of burst step n are (start+n) mod 4. With `burst_mode`=1 they are start XOR n. The upper address bits stay fixed for the whole burst.
- R9: After a read start, `dq_out` holds the word at the registered address within the same clock period. `dq_oe` is high only while `out_en_n`=0, and it follows `out_en_n` without waiting for a clock. `dq_out` is 0 whenever `dq_oe` is 0.
- R10: Any write cycle turns the output drive off whatever the value of `out_en_n`. The drive stays off through later burst reads until a strobe starts a new read.
- R11: After reset the device is deselected and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| en2 | input | 1 | Second chip enable, active high |
| en3_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write-all-lanes, active low |
| bwr_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 2 | Per-lane write selects, active low, bit 0 = lane A |
| burst_mode | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr | input | ADDR_W | External word address |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| dq_in | input | 18 | Write data from the pads |
| dq_out | output | 18 | Read data to the pads |
| dq_oe | output | 1 | Pad drive enable |

## Verification
The two strobe paths can fall in the same cycle. The bench lowers both strobes together while write-all is low and new data sits on `dq_in`. It then judges two things: the word read out must be the one stored earlier, and the output must drive, which shows the processor read won and the write was dropped. A second collision is a strobe that arrives while a burst is running. With `en1_n` high the processor strobe must not break the burst: the bench checks that the output keeps the burst's word, or its next word when advance is low, and never the word at the new address.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_RD_START,
    CYC_WR_START,
    CYC_RD_CONT,
    CYC_WR_CONT
  } cyc_e;

  // Low two address bits of burst step `step` from start `base`.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       interleave);
    return interleave ? (base ^ step) : (base + step);
  endfunction

  // Requested lanes: write-all wins, then per-lane selects under the lane enable.
  function automatic logic [LANES-1:0] lane_mask(input logic             gw_n,
                                                 input logic             bwe_n,
                                                 input logic [LANES-1:0] sel_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~sel_n;
    else             return '0;
  endfunction

endpackage

// File: rtl/ssram_decode.sv
module ssram_decode
  import ssram_pkg::*;
(
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             selected,
  output cyc_e             cyc,
  output logic [LANES-1:0] wr_mask,
  output logic             load,
  output logic             advance
);

  logic             enables_ok;
  logic             proc_go;
  logic             start;
  logic [LANES-1:0] req_mask;

  assign enables_ok = !en1_n && en2 && !en3_n;
  assign proc_go    = !proc_strobe_n && !en1_n;
  assign start      = proc_go || !ctrl_strobe_n;
  assign req_mask   = lane_mask(gwr_n, bwr_en_n, lane_sel_n);

  always_comb begin
    cyc     = CYC_NONE;
    wr_mask = '0;
    load    = 1'b0;
    advance = 1'b0;
    if (start) begin
      if (!enables_ok) begin
        cyc = CYC_DESEL;
      end else begin
        load = 1'b1;
        if (proc_go) begin
          cyc = CYC_RD_START;
        end else if (|req_mask) begin
          cyc     = CYC_WR_START;
          wr_mask = req_mask;
        end else begin
          cyc = CYC_RD_START;
        end
      end
    end else if (selected) begin
      advance = !adv_n;
      if (|req_mask) begin
        cyc     = CYC_WR_CONT;
        wr_mask = req_mask;
      end else begin
        cyc = CYC_RD_CONT;
      end
    end
  end

endmodule

// File: rtl/ssram_burst.sv
module ssram_burst
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [ADDR_W-1:0] next_addr;

  assign cur_addr  = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_q, interleave)};
  assign next_addr = {base_q[ADDR_W-1:2],
                      burst_low(base_q[1:0], step_q + 2'd1, interleave)};
  assign eff_addr  = load ? addr_in : (advance ? next_addr : cur_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      step_q <= '0;
    end else if (advance) begin
      step_q <= step_q + 2'd1;
    end
  end

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/ssram_front.sv
module ssram_front
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    en1_n,
  input  logic                    en2,
  input  logic                    en3_n,
  input  logic                    adv_n,
  input  logic                    gwr_n,
  input  logic                    bwr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    burst_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int WORD_W = LANES * LANE_W;

  cyc_e              cyc;
  logic [LANES-1:0]  wr_mask;
  logic              load;
  logic              advance;
  logic              selected;
  logic              drive;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] rd_word;

  ssram_decode i_decode (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .en1_n         (en1_n),
    .en2           (en2),
    .en3_n         (en3_n),
    .adv_n         (adv_n),
    .gwr_n         (gwr_n),
    .bwr_en_n      (bwr_en_n),
    .lane_sel_n    (lane_sel_n),
    .selected      (selected),
    .cyc           (cyc),
    .wr_mask       (wr_mask),
    .load          (load),
    .advance       (advance)
  );

  ssram_burst #(.ADDR_W(ADDR_W)) i_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .advance    (advance),
    .interleave (burst_mode),
    .addr_in    (addr),
    .eff_addr   (eff_addr),
    .cur_addr   (cur_addr)
  );

  ssram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_array (
    .clk     (clk),
    .wr_mask (wr_mask),
    .wr_addr (eff_addr),
    .wr_data (dq_in),
    .rd_addr (cur_addr),
    .rd_data (rd_word)
  );

  // Selection and drive state; drive is only ever set by a strobe read start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected <= 1'b0;
      drive    <= 1'b0;
    end else begin
      unique case (cyc)
        CYC_DESEL: begin
          selected <= 1'b0;
          drive    <= 1'b0;
        end
        CYC_RD_START: begin
          selected <= 1'b1;
          drive    <= 1'b1;
        end
        CYC_WR_START: begin
          selected <= 1'b1;
          drive    <= 1'b0;
        end
        CYC_WR_CONT: drive <= 1'b0;
        default: ;
      endcase
    end
  end

  assign dq_oe  = drive && !out_en_n;
  assign dq_out = dq_oe ? rd_word : '0;

endmodule

// File: rtl/ssram_front_chk.sv
module ssram_front_chk
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              en1_n,
  input logic              en2,
  input logic              en3_n,
  input logic              adv_n,
  input logic              out_en_n,
  input logic              dq_oe,
  input cyc_e              cyc,
  input logic [LANES-1:0]  wr_mask,
  input logic              load,
  input logic [ADDR_W-1:0] cur_addr
);

  a_r1_load_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!en1_n && en2 && !en3_n));

  a_r1_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |=> !dq_oe);

  a_r3_proc_needs_en1: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_n && ctrl_strobe_n) |-> !load);

  a_r4_proc_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !en1_n) |-> (wr_mask == '0));

  a_r6_hold_address: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == CYC_RD_CONT || cyc == CYC_WR_CONT) && adv_n) |=> $stable(cur_addr));

  a_r9_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !out_en_n);

  a_r10_write_drops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_mask) |=> !dq_oe);

endmodule

bind ssram_front ssram_front_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .en1_n         (en1_n),
  .en2           (en2),
  .en3_n         (en3_n),
  .adv_n         (adv_n),
  .out_en_n      (out_en_n),
  .dq_oe         (dq_oe),
  .cyc           (cyc),
  .wr_mask       (wr_mask),
  .load          (load),
  .cur_addr      (cur_addr)
);

// File: tb/test_ssram_front.sv
`timescale 1ns/1ps
module test_ssram_front;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          proc_strobe_n, ctrl_strobe_n, en1_n, en2, en3_n, adv_n;
  logic          gwr_n, bwr_en_n, burst_mode, out_en_n;
  logic [1:0]    lane_sel_n;
  logic [AW-1:0] addr;
  logic [17:0]   dq_in, dq_out;
  logic          dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ssram_front #(.ADDR_W(AW), .LANE_W(9)) i_ssram_front (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .adv_n(adv_n), .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .lane_sel_n(lane_sel_n),
    .burst_mode(burst_mode), .addr(addr), .out_en_n(out_en_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'(a * 1237 + 18'h2B1);
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    proc_strobe_n = 1; ctrl_strobe_n = 1;
    en1_n = 0; en2 = 1; en3_n = 0; adv_n = 1;
    gwr_n = 1; bwr_en_n = 1; lane_sel_n = 2'b11; out_en_n = 0;
  endtask

  task automatic ctrl_wr(input int a, input logic [17:0] d);
    ctrl_strobe_n = 0; addr = AW'(a); dq_in = d; gwr_n = 0;
    tick;
    check("R10 controller write drive off", 18'(dq_oe), 18'd0);
    idle;
  endtask

  task automatic proc_rd(input int a);
    proc_strobe_n = 0; addr = AW'(a);
    tick;
    idle;
  endtask

  task automatic t_reset;
    idle; burst_mode = 0; addr = '0; dq_in = '0;
    rst_n = 0;
    tick; tick;
    check("R11 reset drive", 18'(dq_oe), 18'd0);
    rst_n = 1;
    tick;
    check("R11 idle after reset", 18'(dq_oe), 18'd0);
  endtask

  task automatic t_ctrl_write;
    ctrl_wr(5, 18'h2A5C3);
    proc_rd(5);
    check("R9 read drive", 18'(dq_oe), 18'd1);
    check("R5 R9 same-period read data", dq_out, 18'h2A5C3);
  endtask

  task automatic t_both_strobes;
    proc_strobe_n = 0; ctrl_strobe_n = 0; gwr_n = 0; addr = 5; dq_in = 18'h11111;
    tick;
    check("R2 processor wins, drives", 18'(dq_oe), 18'd1);
    check("R4 write inputs ignored", dq_out, 18'h2A5C3);
    idle;
    tick;
    check("R4 word unchanged", dq_out, 18'h2A5C3);
  endtask

  task automatic t_lanes;
    ctrl_wr(8, 18'h00000);
    ctrl_strobe_n = 0; addr = 8; dq_in = 18'h3FFFF; gwr_n = 1; bwr_en_n = 0; lane_sel_n = 2'b10;
    tick; idle;
    ctrl_strobe_n = 0; addr = 8; dq_in = 18'h2AAAA; bwr_en_n = 0; lane_sel_n = 2'b01;
    tick; idle;
    ctrl_strobe_n = 0; addr = 8; dq_in = 18'h00000; bwr_en_n = 1; lane_sel_n = 2'b00;
    tick;
    check("R7 no lane enable means read", 18'(dq_oe), 18'd1);
    check("R7 lane merge", dq_out, 18'h2ABFF);
    idle;
  endtask

  task automatic t_burst_orders;
    for (int a = 12; a < 16; a++) ctrl_wr(a, pat(a));
    burst_mode = 0;
    proc_rd(14);
    check("R8 linear first", dq_out, pat(14));
    adv_n = 0;
    tick; check("R8 R6 linear step1", dq_out, pat(15));
    tick; check("R8 linear wrap", dq_out, pat(12));
    tick; check("R8 linear step3", dq_out, pat(13));
    tick; check("R8 linear back to start", dq_out, pat(14));
    adv_n = 1;
    tick; check("R6 hold", dq_out, pat(14));
    burst_mode = 1;
    proc_rd(13);
    check("R8 interleaved first", dq_out, pat(13));
    adv_n = 0;
    tick; check("R8 interleaved step1", dq_out, pat(12));
    tick; check("R8 interleaved step2", dq_out, pat(15));
    tick; check("R8 interleaved step3", dq_out, pat(14));
    idle; burst_mode = 0;
  endtask

  task automatic t_proc_en1;
    proc_rd(14);
    proc_strobe_n = 0; en1_n = 1; addr = 3; adv_n = 1;
    tick;
    check("R3 ignored strobe keeps drive", 18'(dq_oe), 18'd1);
    check("R3 ignored strobe keeps word", dq_out, pat(14));
    adv_n = 0;
    tick;
    check("R3 ignored strobe continues burst", dq_out, pat(15));
    idle;
  endtask

  task automatic t_oe_async;
    out_en_n = 1; #1;
    check("R9 oe off without clock", 18'(dq_oe), 18'd0);
    check("R9 data zero when off", dq_out, 18'd0);
    out_en_n = 0; #1;
    check("R9 oe on without clock", 18'(dq_oe), 18'd1);
  endtask

  task automatic t_write_off;
    proc_rd(12);
    gwr_n = 0; dq_in = 18'h0F0F0; adv_n = 1;
    tick;
    check("R10 burst write drive off", 18'(dq_oe), 18'd0);
    idle; adv_n = 0;
    tick;
    check("R10 stays off on burst read", 18'(dq_oe), 18'd0);
    idle;
    proc_rd(12);
    check("R10 strobe read restores drive", 18'(dq_oe), 18'd1);
    check("R6 burst write landed", dq_out, 18'h0F0F0);
  endtask

  task automatic t_burst_write;
    ctrl_wr(20, 18'h1D0D0);
    gwr_n = 0; adv_n = 0; dq_in = 18'h1D1D1;
    tick; idle;
    proc_rd(21);
    check("R6 advanced write", dq_out, 18'h1D1D1);
    proc_rd(20);
    check("R5 start write", dq_out, 18'h1D0D0);
  endtask

  task automatic t_deselect;
    proc_strobe_n = 0; en2 = 0; addr = 20;
    tick;
    check("R1 deselect drive off", 18'(dq_oe), 18'd0);
    idle;
    gwr_n = 0; adv_n = 0; dq_in = 18'h3E3E3;
    tick;
    check("R1 deselected no drive", 18'(dq_oe), 18'd0);
    idle;
    proc_rd(20);
    check("R1 no write while deselected (20)", dq_out, 18'h1D0D0);
    proc_rd(21);
    check("R1 no write while deselected (21)", dq_out, 18'h1D1D1);
    ctrl_strobe_n = 0; en3_n = 1; gwr_n = 0; addr = 20; dq_in = 18'h3E3E3;
    tick;
    check("R1 en3 deselect", 18'(dq_oe), 18'd0);
    idle;
    proc_rd(20);
    check("R1 en3 blocked write", dq_out, 18'h1D0D0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    t_reset;
    t_ctrl_write;
    t_both_strobes;
    t_lanes;
    t_burst_orders;
    t_proc_en1;
    t_oe_async;
    t_write_off;
    t_burst_write;
    t_deselect;
    finish_run;
  end

endmodule